// File: doc/BRIEF.md
# Banked Support-Register File with Indirect TLB Access

This block serves the support-register move instructions of a processor core. It keeps four banks of sixteen 32-bit support registers. A 2-bit bank field, taken from the low bits of a core control register, picks the bank that every read and write in a cycle uses. Banks 0 and 3 behave as plain register files.

Banks 1 and 2 are memory-management banks. Each one owns a private, software-managed translation table of 4 sets with 16 entries each. Every entry holds a 32-bit hi word and a 32-bit lo word. A select register in the bank picks one entry. Two mirror registers and a cause register give indirect access to it. Writing the lo mirror commits the whole entry. The entry's hi word comes from the cause register, and writing the hi mirror also loads the cause register.

If the entry being overwritten was valid, the block pulses an invalidate request for the old virtual page, so that a translation cache further downstream can drop it. Reads in these banks refresh the mirrors from the selected entry.

Top module: `tlb_bank_regs`

## Requirements
- R1: After reset, every support register in all four banks and every table entry in both memory-management banks is zero, `rd_data_o` is zero and `inval_o` is low.
- R2: A write in bank 0 or bank 3 changes only the addressed register of that bank. Writing register 5 or 6 there neither touches register 7 nor commits an entry nor raises `inval_o`, and reads there return the stored register value. Each bank's registers are independent of the other banks.
- R3: In bank 1 or 2, a write to register 6 (hi mirror) also stores the same value into register 7 (cause).
- R4: In bank 1 or 2, a write to register 5 (lo mirror) commits the entry picked by register 4 (select). Select bits [5:4] give the set and bits [3:0] give the index, and higher select bits are ignored. The entry's lo word takes the written data and its hi word takes the current cause register.
- R5: In bank 1 or 2, a read first loads the selected entry's hi and lo words into registers 6 and 5, then returns the addressed register. A read of register 6 or 5 therefore returns the entry's hi or lo word. Read data appears one clock after `rd_en_i`.
- R6: When a commit overwrites an entry whose old lo word has bit 3 (valid) set, `inval_o` is high for exactly the one cycle following that clock edge. `inval_addr_o` then carries bits [31:13] of the old hi word, with bits [12:0] zero, so pages are 8 KB.
- R7: When a commit overwrites an entry whose old lo bit 3 is clear, `inval_o` stays low.
- R8: Bank 1 and bank 2 each have their own table. An entry committed through one bank is not visible through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel_i | input | 2 | Bank selected for this cycle's access |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Register number written |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 4 | Register number read |
| rd_data_o | output | 32 | Read data, valid one cycle after the strobe |
| inval_o | output | 1 | One-cycle page-invalidate request |
| inval_addr_o | output | 32 | Page address of the invalidate request |

## Verification
The hardest case to reach from the ports is an invalidate for a previously valid entry. It needs three things to line up: an entry committed with its valid bit set, a cause register that has since moved to a different value, and a second commit to the same set and index. The stimulus builds this on purpose. It commits a valid entry, rewrites the hi mirror so that the cause register changes, and then overwrites the entry. The pulse must carry the old page address and not the new one. The same chain runs at the last set and index with an all-ones tag. A second overwrite follows it to show that no pulse appears once the valid bit has been cleared.

// File: rtl/tlb_bank_regs.sv
module tlb_bank_regs #(
  parameter int DW         = 32,
  parameter int REG_AW     = 4,
  parameter int SET_W      = 2,
  parameter int IDX_W      = 4,
  parameter int PAGE_SHIFT = 13,
  parameter int VALID_BIT  = 3,
  parameter int SEL_REG    = 4,
  parameter int LO_REG     = 5,
  parameter int HI_REG     = 6,
  parameter int CAUSE_REG  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bank_sel_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              inval_o,
  output logic [DW-1:0]     inval_addr_o
);
  localparam int NREG = 1 << REG_AW;
  localparam int EW   = SET_W + IDX_W;
  localparam int NENT = 1 << EW;

  logic [DW-1:0] rf     [4][NREG];
  logic [DW-1:0] tlb_hi [2][NENT];
  logic [DW-1:0] tlb_lo [2][NENT];

  logic          mmu, tsel, commit, hi_wr, refresh;
  logic [EW-1:0] ent;
  logic [DW-1:0] old_hi, old_lo, cause_now;

  assign mmu       = (bank_sel_i == 2'd1) || (bank_sel_i == 2'd2);
  assign tsel      = bank_sel_i[1];
  assign ent       = rf[bank_sel_i][SEL_REG][EW-1:0];
  assign old_hi    = tlb_hi[tsel][ent];
  assign old_lo    = tlb_lo[tsel][ent];
  assign cause_now = rf[bank_sel_i][CAUSE_REG];
  assign commit    = wr_en_i && mmu && (wr_addr_i == REG_AW'(LO_REG));
  assign hi_wr     = wr_en_i && mmu && (wr_addr_i == REG_AW'(HI_REG));
  assign refresh   = rd_en_i && mmu;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < NREG; r++) rf[b][r] <= '0;
      for (int t = 0; t < 2; t++)
        for (int e = 0; e < NENT; e++) begin
          tlb_hi[t][e] <= '0;
          tlb_lo[t][e] <= '0;
        end
      rd_data_o    <= '0;
      inval_o      <= 1'b0;
      inval_addr_o <= '0;
    end else begin
      inval_o      <= commit && old_lo[VALID_BIT];
      inval_addr_o <= commit ? {old_hi[DW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}} : '0;
      if (rd_en_i) begin
        if (mmu && rd_addr_i == REG_AW'(HI_REG))      rd_data_o <= old_hi;
        else if (mmu && rd_addr_i == REG_AW'(LO_REG)) rd_data_o <= old_lo;
        else                                          rd_data_o <= rf[bank_sel_i][rd_addr_i];
      end
      if (refresh) begin
        rf[bank_sel_i][HI_REG] <= old_hi;
        rf[bank_sel_i][LO_REG] <= old_lo;
      end
      if (wr_en_i) rf[bank_sel_i][wr_addr_i] <= wr_data_i;
      if (hi_wr)   rf[bank_sel_i][CAUSE_REG] <= wr_data_i;
      if (commit) begin
        tlb_lo[tsel][ent] <= wr_data_i;
        tlb_hi[tsel][ent] <= cause_now;
      end
    end
  end

  // R3
  cause_follows_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> (bank_sel_i != $past(bank_sel_i)) || (cause_now == $past(wr_data_i)));

  // R2
  plain_bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !mmu) |=> !inval_o && $stable(rf[1][CAUSE_REG]) && $stable(rf[2][CAUSE_REG]));

  // R5
  mirror_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !wr_en_i && bank_sel_i == 2'd1) |=> rf[1][LO_REG] == $past(tlb_lo[0][ent]));

  // R6
  inval_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_o |-> $past(wr_en_i && mmu && wr_addr_i == REG_AW'(LO_REG)));

  // R7
  no_inval_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !old_lo[VALID_BIT]) |=> !inval_o);
endmodule

// File: tb/tlb_bank_regs_bench.sv
`timescale 1ns/1ps
module tlb_bank_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bank_sel_i = '0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [3:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        inval_o;
  logic [31:0] inval_addr_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tlb_bank_regs u_tlb_bank_regs (
    .clk(clk), .rst_n(rst_n), .bank_sel_i(bank_sel_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .inval_o(inval_o), .inval_addr_o(inval_addr_o)
  );

  // vector: bank, write?, reg, wdata, check read?, expected read, expected inval, expected page
  function automatic logic [104:0] v(input logic [1:0] b, input logic w, input logic [3:0] a,
                                     input logic [31:0] d, input logic c, input logic [31:0] e,
                                     input logic i, input logic [31:0] ia);
    return {b, w, a, d, c, e, i, ia};
  endfunction

  localparam int NV = 30;
  localparam logic [104:0] VEC [NV] = '{
    v(2'd0, 1, 4'd6, 32'hAAAA0001, 0, 32'h0,        0, 32'h0),        // R2
    v(2'd0, 0, 4'd7, 32'h0,        1, 32'h0,        0, 32'h0),        // R2 cause untouched
    v(2'd0, 0, 4'd6, 32'h0,        1, 32'hAAAA0001, 0, 32'h0),        // R2
    v(2'd3, 0, 4'd6, 32'h0,        1, 32'h0,        0, 32'h0),        // R2 bank isolation
    v(2'd1, 1, 4'd4, 32'h00000025, 0, 32'h0,        0, 32'h0),
    v(2'd1, 1, 4'd6, 32'h80002123, 0, 32'h0,        0, 32'h0),
    v(2'd1, 0, 4'd7, 32'h0,        1, 32'h80002123, 0, 32'h0),        // R3
    v(2'd1, 1, 4'd5, 32'h00000008, 0, 32'h0,        0, 32'h0),        // R7 old empty
    v(2'd1, 1, 4'd6, 32'h11112000, 0, 32'h0,        0, 32'h0),
    v(2'd1, 0, 4'd4, 32'h0,        1, 32'h00000025, 0, 32'h0),        // R5
    v(2'd1, 0, 4'd6, 32'h0,        1, 32'h80002123, 0, 32'h0),        // R4 R5 hi
    v(2'd1, 0, 4'd5, 32'h0,        1, 32'h00000008, 0, 32'h0),        // R4 R5 lo
    v(2'd1, 0, 4'd7, 32'h0,        1, 32'h11112000, 0, 32'h0),        // R3
    v(2'd1, 1, 4'd5, 32'h00000001, 0, 32'h0,        1, 32'h80002000), // R6
    v(2'd1, 1, 4'd5, 32'h00000002, 0, 32'h0,        0, 32'h0),        // R7
    v(2'd2, 1, 4'd4, 32'h00000025, 0, 32'h0,        0, 32'h0),
    v(2'd2, 0, 4'd6, 32'h0,        1, 32'h0,        0, 32'h0),        // R8
    v(2'd1, 0, 4'd6, 32'h0,        1, 32'h11112000, 0, 32'h0),        // R4
    v(2'd1, 0, 4'd5, 32'h0,        1, 32'h00000002, 0, 32'h0),        // R4
    v(2'd1, 1, 4'd4, 32'h00000005, 0, 32'h0,        0, 32'h0),
    v(2'd1, 0, 4'd5, 32'h0,        1, 32'h0,        0, 32'h0),        // R4 set field
    v(2'd3, 1, 4'd5, 32'h000000FF, 0, 32'h0,        0, 32'h0),        // R2
    v(2'd3, 0, 4'd5, 32'h0,        1, 32'h000000FF, 0, 32'h0),        // R2
    v(2'd1, 1, 4'd4, 32'h00000025, 0, 32'h0,        0, 32'h0),
    v(2'd1, 0, 4'd5, 32'h0,        1, 32'h00000002, 0, 32'h0),        // R2 table untouched
    v(2'd2, 1, 4'd6, 32'hFFFFFFFF, 0, 32'h0,        0, 32'h0),
    v(2'd2, 1, 4'd4, 32'h0000003F, 0, 32'h0,        0, 32'h0),
    v(2'd2, 1, 4'd5, 32'h00000008, 0, 32'h0,        0, 32'h0),        // R7
    v(2'd2, 1, 4'd5, 32'h00000000, 0, 32'h0,        1, 32'hFFFFE000), // R6 last entry
    v(2'd2, 0, 4'd5, 32'h0,        1, 32'h0,        0, 32'h0)         // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] b, input logic w, input logic [3:0] a, input logic [31:0] d);
    bank_sel_i = b;
    wr_en_i    = w;
    wr_addr_i  = a;
    wr_data_i  = d;
    rd_en_i    = !w;
    rd_addr_i  = a;
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0;
    rd_en_i = 1'b0;
  endtask

  initial begin
    #(100000 * 5);
    tests++;
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rd_data", rd_data_o, 32'h0);
    check("R1 inval", {31'h0, inval_o}, 32'h0);
    op(2'd1, 0, 4'd5, 32'h0);
    check("R1 entry", rd_data_o, 32'h0);
    op(2'd0, 0, 4'd9, 32'h0);
    check("R1 reg", rd_data_o, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [104:0] t;
      t = VEC[k];
      op(t[104:103], t[102], t[101:98], t[97:66]);
      if (t[65]) check($sformatf("R2-R8 vec%0d read", k), rd_data_o, t[64:33]);
      check($sformatf("R6/R7 vec%0d inval", k), {31'h0, inval_o}, {31'h0, t[32]});
      if (t[32]) check($sformatf("R6 vec%0d page", k), inval_addr_o, t[31:0]);
    end

    // R4: select bits above [5:0] ignored
    op(2'd2, 1, 4'd6, 32'h0000A000);
    op(2'd2, 1, 4'd4, 32'hFFFFFF3F);
    op(2'd2, 1, 4'd5, 32'h00000009);
    check("R7 stale lo", {31'h0, inval_o}, 32'h0);
    op(2'd2, 1, 4'd4, 32'h0000003F);
    op(2'd2, 0, 4'd6, 32'h0);
    check("R4 upper select", rd_data_o, 32'h0000A000);

    // R1: reset in the middle clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 out after reset", rd_data_o, 32'h0);
    op(2'd1, 1, 4'd4, 32'h00000025);
    op(2'd1, 0, 4'd5, 32'h0);
    check("R1 entry cleared", rd_data_o, 32'h0);
    op(2'd1, 1, 4'd5, 32'h00000004);
    check("R1 valid cleared", {31'h0, inval_o}, 32'h0);
    op(2'd0, 0, 4'd6, 32'h0);
    check("R1 bank0 cleared", rd_data_o, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule